// File: doc/BRIEF.md
# Rotating-Priority Bus Grant Unit with I/O Bandwidth Cap

This block decides which of several nodes on a shared system bus owns the next bus transaction. Ordinary nodes take turns under a rotating priority. After a node wins, it drops to the bottom of the order and the search starts at the node after it. One node index is set aside for an I/O agent. That agent may win only a limited number of grants in each group of consecutive grants, so it cannot take more than a fixed share of the bus.

Arbitration runs ahead of the bus. The unit holds the winner of the next slot on its grant outputs while the current transaction is still running. When the bus signals that a slot has been consumed, the held grant is retired. In the same clock edge the unit picks and registers the next winner. When the I/O agent has used its quota but is the only node asking for the bus, a parameter lets it win anyway so the bus does not sit idle.

Top module: `bus_rr_arbiter`

## Requirements
- R1: After reset `gnt_vld_o` is 0 and `gnt_o` is all zeros. The first search starts at node 0, so node 0 wins when every node requests.
- R2: While `gnt_vld_o` is 1, exactly one bit of `gnt_o` is set, and bit i means node i. While `gnt_vld_o` is 0, `gnt_o` is all zeros.
- R3: When no grant is held and at least one request can be granted at a rising edge, `gnt_vld_o` rises after that edge. It names a node whose request was high at that edge.
- R4: A held grant keeps the same value until a clock edge at which `done_i` is 1. When no grant is held, `done_i` has no effect.
- R5: At an edge where `done_i` is 1 and a grant is held, the next winner is chosen from the current requests and shows on the outputs after that same edge. There is no idle cycle between grants.
- R6: The search for a winner begins at the node one index above the most recent winner and wraps from node N-1 to node 0.
- R7: Grants are counted in aligned groups of `WIN_LEN` (default 4), starting from reset. Within one group, the I/O node (default index 7) receives at most `IO_QUOTA` (default 1) grants that are charged to its quota. Once the quota is used up, the I/O request is ignored while any other node requests.
- R8: With `IDLE_BYPASS` set, an I/O node that has used its quota still wins when it is the only requester. Such a grant fills a slot of the current group but is not charged to the quota.
- R9: At an edge where a new grant may be loaded but no request can be granted, `gnt_vld_o` falls to 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| req_i | input | N_NODES | Per-node request lines; bit i is node i |
| done_i | input | 1 | One-cycle pulse: the slot named by the held grant has been consumed |
| gnt_o | output | N_NODES | One-hot winner of the next bus slot |
| gnt_vld_o | output | 1 | High while `gnt_o` names a valid winner |

## Verification
Two functions can act in the same clock edge: retiring a held grant on `done_i`, and choosing a new winner, which also updates the rotation pointer and the quota window. The bench provokes this overlap with back-to-back `done_i` pulses while several nodes keep requesting. It then judges every cycle's winner against a hand-derived rotation sequence. The second case is a window boundary falling in the same edge as an I/O request. The bench checks that the quota reopens exactly on the fifth grant, including when the previous group held a bypass grant.

// File: rtl/bus_arb_pkg.sv
package bus_arb_pkg;

  // index reached by stepping 'off' positions from 'base' on a ring of 'n'
  function automatic int ring_step(input int base, input int off, input int n);
    int s;
    s = base + off;
    if (s >= n) s = s - n;
    return s;
  endfunction

endpackage

// File: rtl/rr_pick.sv
module rr_pick #(
  parameter int N_NODES = 8,
  localparam int IDX_W = (N_NODES > 1) ? $clog2(N_NODES) : 1
) (
  input  logic [N_NODES-1:0] req_i,
  input  logic [IDX_W-1:0]   start_i,
  output logic               found_o,
  output logic [IDX_W-1:0]   idx_o
);

  always_comb begin
    found_o = 1'b0;
    idx_o   = '0;
    for (int k = 0; k < N_NODES; k++) begin
      int cand;
      cand = bus_arb_pkg::ring_step(int'(start_i), k, N_NODES);
      if (!found_o && req_i[cand]) begin
        found_o = 1'b1;
        idx_o   = IDX_W'(cand);
      end
    end
  end

endmodule

// File: rtl/io_quota.sv
module io_quota #(
  parameter int WIN_LEN  = 4,
  parameter int IO_QUOTA = 1,
  localparam int POS_W = $clog2(WIN_LEN + 1),
  localparam int CNT_W = $clog2(IO_QUOTA + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic issue_i,
  input  logic charge_i,
  output logic quota_ok_o
);

  logic [POS_W-1:0] pos_q, pos_d;
  logic [CNT_W-1:0] used_q, used_d;
  logic             wrap;

  assign wrap       = (pos_q == POS_W'(WIN_LEN - 1));
  assign quota_ok_o = (used_q < CNT_W'(IO_QUOTA));

  always_comb begin
    pos_d  = pos_q;
    used_d = used_q;
    if (issue_i) begin
      if (wrap) begin
        pos_d  = '0;
        used_d = '0;
      end else begin
        pos_d = pos_q + POS_W'(1);
        if (charge_i) used_d = used_q + CNT_W'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pos_q  <= '0;
      used_q <= '0;
    end else if (issue_i) begin
      pos_q  <= pos_d;
      used_q <= used_d;
    end
  end

endmodule

// File: rtl/bus_rr_arbiter.sv
module bus_rr_arbiter #(
  parameter int N_NODES     = 8,
  parameter int IO_IDX      = 7,
  parameter int WIN_LEN     = 4,
  parameter int IO_QUOTA    = 1,
  parameter bit IDLE_BYPASS = 1'b1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [N_NODES-1:0] req_i,
  input  logic               done_i,
  output logic [N_NODES-1:0] gnt_o,
  output logic               gnt_vld_o
);

  localparam int IDX_W = (N_NODES > 1) ? $clog2(N_NODES) : 1;
  localparam logic [N_NODES-1:0] IO_MASK = N_NODES'(1) << IO_IDX;

  logic [IDX_W-1:0]   ptr_q, ptr_d;
  logic [N_NODES-1:0] gnt_q, gnt_d;
  logic               vld_q, vld_d;

  logic               io_ok, bypass, others, load, issue, charge, found;
  logic [N_NODES-1:0] elig;
  logic [IDX_W-1:0]   win_idx;

  assign others = |(req_i & ~IO_MASK);
  assign bypass = IDLE_BYPASS && !io_ok && req_i[IO_IDX] && !others;
  assign elig   = (io_ok || bypass) ? req_i : (req_i & ~IO_MASK);
  assign load   = !vld_q || done_i;
  assign issue  = load && found;
  assign charge = (win_idx == IDX_W'(IO_IDX)) && io_ok;

  rr_pick #(.N_NODES(N_NODES)) u_pick (
    .req_i   (elig),
    .start_i (ptr_q),
    .found_o (found),
    .idx_o   (win_idx)
  );

  io_quota #(.WIN_LEN(WIN_LEN), .IO_QUOTA(IO_QUOTA)) u_quota (
    .clk        (clk),
    .rst_n      (rst_n),
    .issue_i    (issue),
    .charge_i   (charge),
    .quota_ok_o (io_ok)
  );

  always_comb begin
    ptr_d = ptr_q;
    gnt_d = gnt_q;
    vld_d = vld_q;
    if (load) begin
      vld_d = found;
      gnt_d = found ? (N_NODES'(1) << win_idx) : '0;
      if (found)
        ptr_d = (win_idx == IDX_W'(N_NODES - 1)) ? '0 : win_idx + IDX_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr_q <= '0;
      gnt_q <= '0;
      vld_q <= 1'b0;
    end else if (load) begin
      ptr_q <= ptr_d;
      gnt_q <= gnt_d;
      vld_q <= vld_d;
    end
  end

  assign gnt_o     = gnt_q;
  assign gnt_vld_o = vld_q;

endmodule

// File: rtl/bus_rr_arbiter_chk.sv
module bus_rr_arbiter_chk #(
  parameter int N_NODES  = 8,
  parameter int IO_IDX   = 7,
  parameter int WIN_LEN  = 4,
  parameter int IO_QUOTA = 1
) (
  input logic               clk,
  input logic               rst_n,
  input logic [N_NODES-1:0] req_i,
  input logic               done_i,
  input logic [N_NODES-1:0] gnt_o,
  input logic               gnt_vld_o
);

  logic prev_load, prev_others;
  int   seen_pos, seen_io;
  logic new_issue;

  assign new_issue = prev_load && gnt_vld_o;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_load   <= 1'b0;
      prev_others <= 1'b0;
      seen_pos    <= 0;
      seen_io     <= 0;
    end else begin
      prev_load   <= !gnt_vld_o || done_i;
      prev_others <= |(req_i & ~(N_NODES'(1) << IO_IDX));
      if (new_issue) begin
        if (seen_pos == WIN_LEN - 1) begin
          seen_pos <= 0;
          seen_io  <= 0;
        end else begin
          seen_pos <= seen_pos + 1;
          if (gnt_o[IO_IDX] && prev_others) seen_io <= seen_io + 1;
        end
      end
    end
  end

  AST_GNT_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    gnt_vld_o |-> $countones(gnt_o) == 1); // R2

  AST_GNT_ZERO_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !gnt_vld_o |-> gnt_o == '0); // R2

  AST_GRANT_TO_REQUESTER: assert property (@(posedge clk) disable iff (!rst_n)
    ((!gnt_vld_o || done_i) && req_i != '0) |=> (gnt_vld_o && (gnt_o & $past(req_i)) != '0)); // R3

  AST_HOLD_UNTIL_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    (gnt_vld_o && !done_i) |=> (gnt_vld_o && $stable(gnt_o))); // R4

  AST_DROP_WHEN_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    ((!gnt_vld_o || done_i) && req_i == '0) |=> !gnt_vld_o); // R9

  AST_IO_CAP: assert property (@(posedge clk) disable iff (!rst_n)
    seen_io <= IO_QUOTA); // R7

endmodule

bind bus_rr_arbiter bus_rr_arbiter_chk #(
  .N_NODES(N_NODES), .IO_IDX(IO_IDX), .WIN_LEN(WIN_LEN), .IO_QUOTA(IO_QUOTA)
) u_chk (
  .clk(clk), .rst_n(rst_n), .req_i(req_i), .done_i(done_i),
  .gnt_o(gnt_o), .gnt_vld_o(gnt_vld_o)
);

// File: tb/bus_rr_arbiter_test.sv
`timescale 1ns/1ps
module bus_rr_arbiter_test;

  localparam int N = 8;

  logic         clk;
  logic         rst_n;
  logic [N-1:0] req;
  logic         done;
  logic [N-1:0] gnt;
  logic         gnt_vld;

  int checks = 0;
  int errors = 0;

  bus_rr_arbiter uut (
    .clk(clk), .rst_n(rst_n), .req_i(req), .done_i(done),
    .gnt_o(gnt), .gnt_vld_o(gnt_vld)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  task automatic expect_out(input logic ev, input int idx, input string tag);
    logic [N-1:0] eg;
    eg = ev ? (N'(1) << idx) : '0;
    checks++;
    if (gnt_vld !== ev || gnt !== eg) begin
      errors++;
      $display("FAIL %s: vld=%0b gnt=%h expected vld=%0b gnt=%h", tag, gnt_vld, gnt, ev, eg);
    end
  endtask

  task automatic cyc(input logic [N-1:0] r, input logic d, input logic ev,
                     input int idx, input string tag);
    @(negedge clk);
    req  = r;
    done = d;
    @(posedge clk);
    #1;
    expect_out(ev, idx, tag);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    req   = '0;
    done  = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic t_reset();
    do_reset();
    #1;
    expect_out(1'b0, 0, "R1 reset state");
  endtask

  task automatic t_rotate();
    do_reset();
    cyc(8'hFF, 1'b0, 1'b1, 0, "R1 R3 first winner node0");
    cyc(8'hFF, 1'b0, 1'b1, 0, "R4 hold without done");
    cyc(8'hFF, 1'b0, 1'b1, 0, "R4 hold without done");
    for (int i = 1; i < 8; i++)
      cyc(8'hFF, 1'b1, 1'b1, i, "R5 R6 back-to-back rotation");
    cyc(8'hFF, 1'b1, 1'b1, 0, "R6 wrap to node0");
    cyc(8'h24, 1'b1, 1'b1, 2, "R6 sparse from node1");
    cyc(8'h24, 1'b1, 1'b1, 5, "R6 sparse next");
    cyc(8'h24, 1'b1, 1'b1, 2, "R6 sparse wrap");
    cyc(8'h00, 1'b1, 1'b0, 0, "R9 no request drops valid");
    cyc(8'h00, 1'b1, 1'b0, 0, "R4 done without grant ignored");
    cyc(8'h00, 1'b0, 1'b0, 0, "R2 idle grant zero");
  endtask

  task automatic t_quota();
    int exp_seq[9] = '{1, 7, 1, 1, 7, 1, 1, 1, 7};
    do_reset();
    cyc(8'h82, 1'b0, 1'b1, exp_seq[0], "R7 quota issue1");
    for (int i = 1; i < 9; i++)
      cyc(8'h82, 1'b1, 1'b1, exp_seq[i], "R7 quota window sequence");
  endtask

  task automatic t_bypass();
    do_reset();
    cyc(8'h80, 1'b0, 1'b1, 7, "R8 io alone first grant");
    cyc(8'h80, 1'b1, 1'b1, 7, "R8 bypass when quota used");
    cyc(8'h82, 1'b1, 1'b1, 1, "R7 io masked with other requester");
    cyc(8'h82, 1'b1, 1'b1, 1, "R7 io still masked in group");
    cyc(8'h82, 1'b1, 1'b1, 7, "R8 bypass filled a slot, quota reopens");
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    req   = '0;
    done  = 1'b0;
    t_reset();
    t_rotate();
    t_quota();
    t_bypass();
    repeat (3) @(negedge clk);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule